// File: doc/BRIEF.md
# Boot Image RAM Overlay Controller

This block lets a 32K static RAM take the place of the two 16K system ROM images on an 8-bit Z80-style bus. One half of the RAM holds the 128 BASIC image and the other half holds the disk-OS image. When the overlay is active, memory cycles in the lowest 16K go to the RAM, and the real ROM select is held off. Software can then boot its own menu or OS variant in place of the fixed firmware.

Software controls the overlay through a write-only I/O control register. The register is decoded on A0 = 0 and A7 = 0, so it does not collide with a keyboard port that decodes on A7 = 1. The block also snoops writes to the memory paging port and keeps the bit that pages the 48K BASIC ROM. While that ROM is paged, the overlay is removed.

The top RAM address line picks the bank. It follows the disk-OS paging signal OR-ed with a force bit, so an OS image can be copied into its bank while the disk OS itself is not paged in. All control state clears on reset.

Top module: `ovl_overlay_ctrl`

## Requirements
- R1: At a rising clock edge where iorq_ni = 0, wr_ni = 0, addr_i[0] = 0 and addr_i[7] = 0, the control register loads data_i. Its fields are: bit0 = write allow, bit1 = overlay enable, bit2 = force disk-OS bank, bit3 = shadow off (active low), bit4 = shadow write allow, bit5 = 512K off (active low).
- R2: An I/O write with addr_i[7] = 1 does not load the control register. An I/O read (rd_ni = 0) at the control port address does not load it either. The control register is write-only, and the block has no data output.
- R3: While rst_ni = 0, the control register and the paging latch are cleared. As a result the overlay, write allow and force are all off, shadow_en_o = 1, shadow_we_o = 0 and ext512_en_o = 1.
- R4: The overlay is active when (bit1 OR bit2) = 1 and the paging latch = 0. During a memory cycle (mreq_ni = 0) with addr_i[15:14] = 0, an active overlay drives ram_cs_no = 0 and rom_cs_no = 1. An inactive overlay drives rom_cs_no = 0 and ram_cs_no = 1.
- R5: ram_oe_no = 0 exactly when the overlay is active, mreq_ni = 0, rd_ni = 0 and addr_i[15:14] = 0.
- R6: ram_we_no = 0 exactly when the overlay is active, bit0 = 1, mreq_ni = 0, wr_ni = 0 and addr_i[15:14] = 0. In every other case, memory writes to the low 16K leave ram_we_no = 1.
- R7: ram_bank_o = dos_act_i OR bit2 on every cycle.
- R8: An I/O write with addr_i[15] = 0 and addr_i[1] = 0 loads data_i[4] into the paging latch at the clock edge. While the latch is 1, the overlay is inactive regardless of the control register.
- R9: A memory cycle with addr_i[15:14] != 0 asserts none of rom_cs_no, ram_cs_no, ram_oe_no and ram_we_no. Nor does any cycle with mreq_ni = 1.
- R10: shadow_en_o = NOT bit3, shadow_we_o = bit4 and ext512_en_o = NOT bit5. Bits 6 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address bus |
| data_i | input | 8 | CPU data bus (sampled on I/O writes) |
| iorq_ni | input | 1 | I/O request, active low |
| mreq_ni | input | 1 | Memory request, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| dos_act_i | input | 1 | Disk-OS image paged in |
| rom_cs_no | output | 1 | Real ROM chip select, active low |
| ram_cs_no | output | 1 | Overlay RAM chip select, active low |
| ram_oe_no | output | 1 | Overlay RAM output enable, active low |
| ram_we_no | output | 1 | Overlay RAM write enable, active low |
| ram_bank_o | output | 1 | Overlay RAM top address line (1 = disk-OS bank) |
| shadow_en_o | output | 1 | Shadow RAM enable |
| shadow_we_o | output | 1 | Shadow RAM write allow |
| ext512_en_o | output | 1 | 512K mode enable |

## Verification
The assertions check several properties on every cycle. The RAM and ROM selects are never both low. A RAM write enable always comes with a RAM select and a write strobe, and an output enable always comes with a read strobe. Nothing is selected outside the low 16K. Writes at addresses with A7 set leave the control outputs unchanged. Once the paging latch is set, the RAM is never selected. Other behaviour only the bench scenarios can show: the exact loaded field values, force-only activation, bank following, write gating by bit0, restoring the overlay when 48K paging is cleared, and the reset values mid-run.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  // control register fields; bit order is the software-visible layout
  typedef struct packed {
    logic ext512_n;
    logic shadow_we;
    logic shadow_n;
    logic force_dos;
    logic ovl_en;
    logic wr_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ovl_port_dec.sv
module ovl_port_dec #(
  parameter int unsigned AW          = 16,
  parameter int unsigned CTRL_LO_BIT = 0,
  parameter int unsigned CTRL_HI_BIT = 7,
  parameter int unsigned PAGE_LO_BIT = 1
) (
  input  logic [AW-1:0] addr_i,
  input  logic          iorq_ni,
  input  logic          wr_ni,
  output logic          ctrl_we_o,
  output logic          page_we_o
);
  localparam int unsigned PAGE_HI_BIT = AW - 1;

  logic io_wr;
  logic unused_addr;

  assign io_wr       = ~iorq_ni & ~wr_ni;
  assign ctrl_we_o   = io_wr & ~addr_i[CTRL_LO_BIT] & ~addr_i[CTRL_HI_BIT];
  assign page_we_o   = io_wr & ~addr_i[PAGE_HI_BIT] & ~addr_i[PAGE_LO_BIT];
  assign unused_addr = ^addr_i;
endmodule

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg
  import ovl_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned PAGE_BIT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic          page_we_i,
  input  logic [DW-1:0] data_i,
  output ctrl_t         ctrl_o,
  output logic          rom48_o
);
  logic unused_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
    end else if (ctrl_we_i) begin
      ctrl_o <= ctrl_t'(data_i[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom48_o <= 1'b0;
    end else if (page_we_i) begin
      rom48_o <= data_i[PAGE_BIT];
    end
  end

  assign unused_data = ^data_i;
endmodule

// File: rtl/ovl_mem_sel.sv
module ovl_mem_sel
  import ovl_pkg::*;
#(
  parameter int unsigned HI_W = 2
) (
  input  logic [HI_W-1:0] addr_hi_i,
  input  logic            mreq_ni,
  input  logic            rd_ni,
  input  logic            wr_ni,
  input  ctrl_t           ctrl_i,
  input  logic            rom48_i,
  input  logic            dos_act_i,
  output logic            rom_cs_no,
  output logic            ram_cs_no,
  output logic            ram_oe_no,
  output logic            ram_we_no,
  output logic            ram_bank_o,
  output logic            shadow_en_o,
  output logic            shadow_we_o,
  output logic            ext512_en_o
);
  logic region;
  logic active;

  assign region = ~mreq_ni & (addr_hi_i == '0);
  // force alone is enough to map RAM so an image can be loaded
  assign active = (ctrl_i.ovl_en | ctrl_i.force_dos) & ~rom48_i;

  always_comb begin
    rom_cs_no = ~(region & ~active);
    ram_cs_no = ~(region & active);
    ram_oe_no = ~(region & active & ~rd_ni);
    ram_we_no = ~(region & active & ctrl_i.wr_en & ~wr_ni);
  end

  assign ram_bank_o  = dos_act_i | ctrl_i.force_dos;
  assign shadow_en_o = ~ctrl_i.shadow_n;
  assign shadow_we_o = ctrl_i.shadow_we;
  assign ext512_en_o = ~ctrl_i.ext512_n;
endmodule

// File: rtl/ovl_overlay_ctrl.sv
module ovl_overlay_ctrl
  import ovl_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned REGION_W = 14,
  parameter int unsigned PAGE_BIT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          iorq_ni,
  input  logic          mreq_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic          dos_act_i,
  output logic          rom_cs_no,
  output logic          ram_cs_no,
  output logic          ram_oe_no,
  output logic          ram_we_no,
  output logic          ram_bank_o,
  output logic          shadow_en_o,
  output logic          shadow_we_o,
  output logic          ext512_en_o
);
  localparam int unsigned HI_W = AW - REGION_W;

  logic  ctrl_we;
  logic  page_we;
  ctrl_t ctrl_q;
  logic  rom48_q;

  ovl_port_dec #(.AW(AW)) u_dec (
    .addr_i    (addr_i),
    .iorq_ni   (iorq_ni),
    .wr_ni     (wr_ni),
    .ctrl_we_o (ctrl_we),
    .page_we_o (page_we)
  );

  ovl_ctrl_reg #(.DW(DW), .PAGE_BIT(PAGE_BIT)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we),
    .page_we_i (page_we),
    .data_i    (data_i),
    .ctrl_o    (ctrl_q),
    .rom48_o   (rom48_q)
  );

  ovl_mem_sel #(.HI_W(HI_W)) u_sel (
    .addr_hi_i   (addr_i[AW-1:REGION_W]),
    .mreq_ni     (mreq_ni),
    .rd_ni       (rd_ni),
    .wr_ni       (wr_ni),
    .ctrl_i      (ctrl_q),
    .rom48_i     (rom48_q),
    .dos_act_i   (dos_act_i),
    .rom_cs_no   (rom_cs_no),
    .ram_cs_no   (ram_cs_no),
    .ram_oe_no   (ram_oe_no),
    .ram_we_no   (ram_we_no),
    .ram_bank_o  (ram_bank_o),
    .shadow_en_o (shadow_en_o),
    .shadow_we_o (shadow_we_o),
    .ext512_en_o (ext512_en_o)
  );
endmodule

// File: rtl/ovl_overlay_ctrl_chk.sv
module ovl_overlay_ctrl_chk #(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned REGION_W = 14,
  parameter int unsigned PAGE_BIT = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] data_i,
  input logic          iorq_ni,
  input logic          mreq_ni,
  input logic          rd_ni,
  input logic          wr_ni,
  input logic          dos_act_i,
  input logic          rom_cs_no,
  input logic          ram_cs_no,
  input logic          ram_oe_no,
  input logic          ram_we_no,
  input logic          ram_bank_o,
  input logic          shadow_en_o,
  input logic          shadow_we_o,
  input logic          ext512_en_o
);
  logic in_low;
  logic page_set;
  logic high_io_wr;
  logic unused_chk;

  assign in_low     = (addr_i[AW-1:REGION_W] == '0);
  assign page_set   = ~iorq_ni & ~wr_ni & ~addr_i[AW-1] & ~addr_i[1] & data_i[PAGE_BIT];
  assign high_io_wr = ~iorq_ni & ~wr_ni & addr_i[7] & (addr_i[AW-1] | addr_i[1]);
  assign unused_chk = ^{dos_act_i, ram_bank_o};

  a_r4_exclusive_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ram_cs_no && !rom_cs_no));

  a_r6_we_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |-> (!ram_cs_no && !wr_ni));

  a_r5_oe_needs_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_oe_no |-> (!ram_cs_no && !rd_ni));

  a_r9_outside_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_ni || !in_low) |-> (rom_cs_no && ram_cs_no && ram_oe_no && ram_we_no));

  a_r2_high_port_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_io_wr |=> $stable({shadow_en_o, shadow_we_o, ext512_en_o}));

  a_r8_rom48_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_set |=> ram_cs_no);
endmodule

bind ovl_overlay_ctrl ovl_overlay_ctrl_chk #(
  .AW(AW), .DW(DW), .REGION_W(REGION_W), .PAGE_BIT(PAGE_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .data_i(data_i),
  .iorq_ni(iorq_ni), .mreq_ni(mreq_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
  .dos_act_i(dos_act_i), .rom_cs_no(rom_cs_no), .ram_cs_no(ram_cs_no),
  .ram_oe_no(ram_oe_no), .ram_we_no(ram_we_no), .ram_bank_o(ram_bank_o),
  .shadow_en_o(shadow_en_o), .shadow_we_o(shadow_we_o), .ext512_en_o(ext512_en_o)
);

// File: tb/tb_ovl_overlay_ctrl.sv
`timescale 1ns/1ps
module tb_ovl_overlay_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        iorq_ni = 1'b1, mreq_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic        dos_act_i = 1'b0;
  logic rom_cs_no, ram_cs_no, ram_oe_no, ram_we_no, ram_bank_o;
  logic shadow_en_o, shadow_we_o, ext512_en_o;

  int checks = 0;
  int errors = 0;
  int m_ctrl = 0;
  int m_page = 0;

  always #2 clk_i = ~clk_i;

  ovl_overlay_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .data_i(data_i),
    .iorq_ni(iorq_ni), .mreq_ni(mreq_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .dos_act_i(dos_act_i), .rom_cs_no(rom_cs_no), .ram_cs_no(ram_cs_no),
    .ram_oe_no(ram_oe_no), .ram_we_no(ram_we_no), .ram_bank_o(ram_bank_o),
    .shadow_en_o(shadow_en_o), .shadow_we_o(shadow_we_o), .ext512_en_o(ext512_en_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model, evaluated from the requirement text
  task automatic compare();
    int bit0, en, frc, act, low, mem;
    bit0 = m_ctrl % 2;
    en   = (m_ctrl / 2) % 2;
    frc  = (m_ctrl / 4) % 2;
    act  = ((en != 0 || frc != 0) && m_page == 0) ? 1 : 0;
    low  = (addr_i < 16'h4000) ? 1 : 0;
    mem  = (!mreq_ni && low != 0) ? 1 : 0;
    if (!rst_ni) begin
      chk("R3", "shadow_en", shadow_en_o, 1);
      chk("R3", "shadow_we", shadow_we_o, 0);
      chk("R3", "ext512_en", ext512_en_o, 1);
      chk("R3", "ram_bank", ram_bank_o, dos_act_i);
      return;
    end
    if (low == 0 && !mreq_ni) begin
      chk("R9", "rom_cs_n", rom_cs_no, 1);
      chk("R9", "ram_cs_n", ram_cs_no, 1);
    end
    chk("R4", "rom_cs_n", rom_cs_no, (mem != 0 && act == 0) ? 0 : 1);
    chk("R4", "ram_cs_n", ram_cs_no, (mem != 0 && act != 0) ? 0 : 1);
    chk("R5", "ram_oe_n", ram_oe_no, (mem != 0 && act != 0 && !rd_ni) ? 0 : 1);
    chk("R6", "ram_we_n", ram_we_no, (mem != 0 && act != 0 && bit0 != 0 && !wr_ni) ? 0 : 1);
    chk("R7", "ram_bank", ram_bank_o, (dos_act_i || frc != 0) ? 1 : 0);
    chk("R10", "shadow_en", shadow_en_o, ((m_ctrl / 8) % 2 == 0) ? 1 : 0);
    chk("R10", "shadow_we", shadow_we_o, (m_ctrl / 16) % 2);
    chk("R10", "ext512_en", ext512_en_o, ((m_ctrl / 32) % 2 == 0) ? 1 : 0);
  endtask

  // one bus cycle: drive after falling edge, compare, update model at rising edge
  task automatic cyc(input logic [15:0] a, input logic [7:0] d, input bit io,
                     input bit mem, input bit rd, input bit wr, input bit dos);
    @(negedge clk_i);
    addr_i = a; data_i = d; iorq_ni = !io; mreq_ni = !mem;
    rd_ni = !rd; wr_ni = !wr; dos_act_i = dos;
    #1 compare();
    @(posedge clk_i);
    if (rst_ni && io && wr) begin
      if (a[0] == 1'b0 && a[7] == 1'b0) m_ctrl = d % 64;     // R1
      if (a[15] == 1'b0 && a[1] == 1'b0) m_page = d[4];      // R8
    end
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    cyc(a, d, 1, 0, 0, 1, 0);
    cyc(16'h0000, 8'h00, 0, 0, 0, 0, 0);
  endtask

  task automatic mem_sweep(input bit dos);
    cyc(16'h0000, 8'h00, 0, 1, 1, 0, dos);
    cyc(16'h2345, 8'h00, 0, 1, 0, 1, dos);
    cyc(16'h3FFF, 8'h00, 0, 1, 1, 0, dos);
    cyc(16'h4000, 8'h00, 0, 1, 1, 0, dos);
    cyc(16'hC000, 8'h00, 0, 1, 0, 1, dos);
  endtask

  initial begin
    fork
      begin
        repeat (3) cyc(16'h0000, 8'h00, 0, 1, 1, 0, 0);   // R3 during reset
        rst_ni = 1'b1;
        mem_sweep(0);
        io_wr(16'h00FE, 8'hFF); mem_sweep(0);              // R2 keyboard port
        cyc(16'h007E, 8'h00, 1, 0, 1, 0, 0); mem_sweep(0); // R2 I/O read
        io_wr(16'h007E, 8'h02); mem_sweep(0); mem_sweep(1); // R1 enable, R6 no write
        io_wr(16'h007E, 8'h03); mem_sweep(1);              // R6 write allowed
        io_wr(16'h007E, 8'h05); mem_sweep(0);              // R4 force only, R7
        io_wr(16'h7FFD, 8'h10); mem_sweep(1);              // R8 48K paged
        io_wr(16'h7FFD, 8'h00); mem_sweep(0);              // R8 restore
        io_wr(16'h007E, 8'h38); mem_sweep(0);              // R10
        io_wr(16'h127E, 8'hC3); mem_sweep(1);              // R10 reserved bits
        rst_ni = 1'b0; m_ctrl = 0; m_page = 0;
        cyc(16'h0000, 8'h00, 0, 1, 1, 0, 1);              // R3 mid-run
        rst_ni = 1'b1;
        mem_sweep(0);
      end
      begin
        repeat (5000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule